// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block places incoming packets into host memory through a circular ring of 16-byte receive descriptors. Software sets up the following through a small register port:

- the ring's base address,
- its length in bytes,
- a producer tail index,
- a control word that enables reception and selects the per-descriptor buffer size.

The block owns the head index. Packet bytes arrive one per cycle on a valid/ready stream, and the last byte of each packet is marked.

For each packet the block reads the two address words of the descriptor at the head. It then streams the payload into that buffer as 32-bit little-endian words. When the buffer is full, or the packet ends, it writes the chunk length and a status word back into the descriptor and advances the head.

A packet that exceeds one buffer continues in the next descriptor. When the head reaches the tail, no descriptor is free. The block then raises an overrun pulse and swallows the rest of that packet. After the final chunk of a packet has been written back, a receive-timer pulse tells the interrupt logic that a complete packet has landed.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset the control word, ring length, head and tail read 0, pkt_ready and mem_req are low and both event pulses are low.
- R2: A ring length write keeps only bits 19:7 of the data (mask 0x000FFF80); head and tail writes keep only the low 16 bits.
- R3: While control bit 1 (receive enable) is 0 at the start of a packet, the whole packet is consumed with no memory access, no event and no head change.
- R4: The buffer size comes from control bits 17:16 and bit 25. With bit 25 = 0, codes 0..3 give 2048, 1024, 512 and 256 bytes. With bit 25 = 1, codes 1..3 give 16384, 8192 and 4096 bytes, and code 0 is invalid. A packet arriving while the size is invalid is consumed with no memory access.
- R5: A descriptor is read as two 32-bit words at base + 16*head (offset 0) and offset 4. The buffer address is {word at offset 4, word at offset 0}. A request holds its address and direction until mem_ack.
- R6: Payload is written as 32-bit words at buffer + 4*k, with the packet's first byte of the chunk in bits 7:0. A partial last word has its unused upper bytes set to 0. Every access is word aligned.
- R7: Each chunk holds the smaller of the remaining packet bytes and the buffer size. A longer packet continues in the following descriptors.
- R8: After each chunk, the chunk length is written to descriptor offset 8 and the status to offset 12. The status has bit 0 (done) and bit 2 (checksum ignored) set, giving 0x5. On the last chunk, bit 1 (end of packet) is also set, giving 0x7, and the written length is the chunk length plus 4.
- R9: The head increases by one after each status write. It becomes 0 when the incremented value equals ring length / 16.
- R10: When head equals tail at the start of a packet or between chunks, ev_overrun pulses for one cycle. The remaining bytes are then consumed with no memory access, and the head does not move.
- R11: ev_rx_timer pulses for one cycle after the status write of a packet's last chunk, once per packet. It never coincides with ev_overrun.
- R12: pkt_ready is low while a descriptor fetch, data write or writeback is in progress.
- R13: A software head write in the same cycle as the block's own head advance is discarded, and the advance takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 base low, 2 base high, 3 ring length, 4 head, 5 tail |
| reg_wdata | input | 32 | Register write data |
| ctrl_q | output | 32 | Control word |
| base_q | output | ADDR_W | Ring base address |
| ring_len_q | output | 32 | Ring length in bytes |
| head_q | output | PTR_W | Head index (next descriptor to fill) |
| tail_q | output | PTR_W | Tail index written by software |
| pkt_valid | input | 1 | Packet byte valid |
| pkt_data | input | 8 | Packet byte |
| pkt_last | input | 1 | Byte is the last of its packet |
| pkt_ready | output | 1 | Block accepts a byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack on a read |
| ev_overrun | output | 1 | One-cycle pulse: no free descriptor |
| ev_rx_timer | output | 1 | One-cycle pulse: packet fully written back |

## Verification
Two actions can land on the head index in the same clock: software rewriting it through the register port, and the block advancing it as the status word's write is acknowledged. The bench watches the memory port for the acknowledge of the status write at descriptor offset 12. In exactly that cycle it issues a head write of an unrelated value. The result is judged by reading the head afterwards: it must equal the old head plus one, not the value software wrote.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

   // register select codes on reg_sel
   localparam logic [2:0] SEL_CTRL     = 3'd0;
   localparam logic [2:0] SEL_BASE_LO  = 3'd1;
   localparam logic [2:0] SEL_BASE_HI  = 3'd2;
   localparam logic [2:0] SEL_RING_LEN = 3'd3;
   localparam logic [2:0] SEL_HEAD     = 3'd4;
   localparam logic [2:0] SEL_TAIL     = 3'd5;

   // control word fields
   localparam int CTRL_EN_BIT   = 1;
   localparam int CTRL_SZ_LSB   = 16;
   localparam int CTRL_EXT_BIT  = 25;

   // ring length keeps bits 19:7
   localparam logic [31:0] RING_LEN_MASK = 32'h000F_FF80;

   // descriptor layout (byte offsets)
   localparam int DESC_SHIFT = 4;
   localparam logic [3:0] OFS_ADDR_LO = 4'd0;
   localparam logic [3:0] OFS_ADDR_HI = 4'd4;
   localparam logic [3:0] OFS_LEN     = 4'd8;
   localparam logic [3:0] OFS_STATUS  = 4'd12;

   // status bits
   localparam int ST_DONE_BIT = 0;
   localparam int ST_EOP_BIT  = 1;
   localparam int ST_NOCS_BIT = 2;

   localparam int FCS_BYTES = 4;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DESC_LO,
      ST_DESC_HI,
      ST_DATA,
      ST_WR_DATA,
      ST_WB_LEN,
      ST_WB_STAT,
      ST_NEXT,
      ST_DRAIN
   } eng_state_e;

endpackage

// File: rtl/rxr_size_dec.sv
// Buffer size decode from the 2-bit code and extension bit (R4).
module rxr_size_dec #(
   parameter int CNT_W = 15
) (
   input  logic [1:0]       code,
   input  logic             ext,
   output logic [CNT_W-1:0] size,
   output logic             valid
);
   localparam logic [CNT_W-1:0] STD_MAX = CNT_W'(2048);
   localparam logic [CNT_W-1:0] EXT_MAX = CNT_W'(16384);

   logic [CNT_W-1:0] raw;

   always_comb begin
      if (ext) begin
         raw   = EXT_MAX >> (code - 2'd1);
         valid = (code != 2'b00);
      end else begin
         raw   = STD_MAX >> code;
         valid = 1'b1;
      end
      size = valid ? raw : '0;
   end
endmodule

// File: rtl/rxr_word_pack.sv
// Collects bytes into one little-endian data word, one register per lane.
module rxr_word_pack #(
   parameter int LANES = 4,
   localparam int LANE_W = $clog2(LANES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               push,
   input  logic [LANE_W-1:0]  lane,
   input  logic [7:0]         din,
   output logic [8*LANES-1:0] word
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               byte_q <= '0;
         else if (clr)                             byte_q <= '0;
         else if (push && lane == LANE_W'(g))      byte_q <= din;
      end
      assign word[8*g +: 8] = byte_q;
   end
endmodule

// File: rtl/rxr_regs.sv
// Software-visible ring registers with head advance (R2, R9, R13).
module rxr_regs
   import rxr_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int PTR_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_sel,
   input  logic [31:0]       reg_wdata,
   input  logic              head_adv,
   output logic [31:0]       ctrl_q,
   output logic [ADDR_W-1:0] base_q,
   output logic [31:0]       ring_len_q,
   output logic [PTR_W-1:0]  head_q,
   output logic [PTR_W-1:0]  tail_q
);
   localparam int HI_W = ADDR_W - 32;

   logic [31:0]      base_lo_q;
   logic [PTR_W-1:0] entries;
   logic [PTR_W:0]   head_inc;
   logic             head_wrap;

   assign entries   = ring_len_q[PTR_W+DESC_SHIFT-1:DESC_SHIFT];
   assign head_inc  = {1'b0, head_q} + 1'b1;
   assign head_wrap = (head_inc == {1'b0, entries});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         base_lo_q  <= '0;
         ring_len_q <= '0;
         tail_q     <= '0;
      end else if (reg_we) begin
         case (reg_sel)
            SEL_CTRL:     ctrl_q     <= reg_wdata;
            SEL_BASE_LO:  base_lo_q  <= reg_wdata;
            SEL_RING_LEN: ring_len_q <= reg_wdata & RING_LEN_MASK;
            SEL_TAIL:     tail_q     <= reg_wdata[PTR_W-1:0];
            default: ;
         endcase
      end
   end

   // engine advance has priority over a software head write (R13)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         head_q <= '0;
      else if (head_adv)
         head_q <= head_wrap ? '0 : head_inc[PTR_W-1:0];
      else if (reg_we && reg_sel == SEL_HEAD)
         head_q <= reg_wdata[PTR_W-1:0];
   end

   if (HI_W > 0) begin : g_base_hi
      logic [HI_W-1:0] base_hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            base_hi_q <= '0;
         else if (reg_we && reg_sel == SEL_BASE_HI)
            base_hi_q <= reg_wdata[HI_W-1:0];
      end
      assign base_q = {base_hi_q, base_lo_q};
   end else begin : g_base_lo_only
      assign base_q = base_lo_q;
   end
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
   import rxr_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int PTR_W  = 16,
   parameter int CNT_W  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_sel,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       ctrl_q,
   output logic [ADDR_W-1:0] base_q,
   output logic [31:0]       ring_len_q,
   output logic [PTR_W-1:0]  head_q,
   output logic [PTR_W-1:0]  tail_q,
   input  logic              pkt_valid,
   input  logic [7:0]        pkt_data,
   input  logic              pkt_last,
   output logic              pkt_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              ev_overrun,
   output logic              ev_rx_timer
);
   localparam int WIDX_W  = CNT_W - 2;
   localparam int DPAD_W  = ADDR_W - PTR_W - DESC_SHIFT;
   localparam int WPAD_W  = ADDR_W - CNT_W;

   if (ADDR_W < 32 || ADDR_W > 64) begin : g_bad_addr_w
      $error("ADDR_W must lie in 32..64");
   end
   if (PTR_W < 4 || PTR_W > 28 || DPAD_W < 1) begin : g_bad_ptr_w
      $error("PTR_W out of range for ADDR_W");
   end
   if (CNT_W < 15 || CNT_W > 24) begin : g_bad_cnt_w
      $error("CNT_W must hold 16384");
   end

   eng_state_e       state_q;
   logic [63:0]      buf_addr_q;
   logic [CNT_W-1:0] chunk_cnt_q;
   logic [WIDX_W-1:0] word_idx_q;
   logic [CNT_W-1:0] bsize_q;
   logic             chunk_end_q;
   logic             pkt_end_q;
   logic             ev_overrun_q;
   logic             ev_timer_q;

   logic [CNT_W-1:0] dec_size;
   logic             dec_valid;
   logic [31:0]      packed_word;
   logic [CNT_W-1:0] cnt_inc;
   logic             chunk_done;
   logic             word_full;
   logic             ring_full;
   logic             head_adv;
   logic             take_byte;
   logic [ADDR_W-1:0] desc_addr;
   logic [ADDR_W-1:0] data_addr;

   rxr_regs #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_sel    (reg_sel),
      .reg_wdata  (reg_wdata),
      .head_adv   (head_adv),
      .ctrl_q     (ctrl_q),
      .base_q     (base_q),
      .ring_len_q (ring_len_q),
      .head_q     (head_q),
      .tail_q     (tail_q)
   );

   rxr_size_dec #(.CNT_W(CNT_W)) u_size (
      .code  (ctrl_q[CTRL_SZ_LSB +: 2]),
      .ext   (ctrl_q[CTRL_EXT_BIT]),
      .size  (dec_size),
      .valid (dec_valid)
   );

   assign take_byte = pkt_valid && pkt_ready && (state_q == ST_DATA);

   rxr_word_pack #(.LANES(4)) u_pack (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   ((state_q == ST_WR_DATA) && mem_ack),
      .push  (take_byte),
      .lane  (chunk_cnt_q[1:0]),
      .din   (pkt_data),
      .word  (packed_word)
   );

   assign ring_full  = (head_q == tail_q);
   assign cnt_inc    = chunk_cnt_q + 1'b1;
   assign chunk_done = pkt_last || (cnt_inc == bsize_q);
   assign word_full  = (chunk_cnt_q[1:0] == 2'd3);
   assign head_adv   = (state_q == ST_WB_STAT) && mem_ack;
   assign desc_addr  = base_q + {{DPAD_W{1'b0}}, head_q, {DESC_SHIFT{1'b0}}};
   assign data_addr  = buf_addr_q[ADDR_W-1:0] + {{WPAD_W{1'b0}}, word_idx_q, 2'b00};

   assign pkt_ready   = (state_q == ST_DATA) || (state_q == ST_DRAIN);
   assign ev_overrun  = ev_overrun_q;
   assign ev_rx_timer = ev_timer_q;

   // memory request mux
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (state_q)
         ST_DESC_LO: begin
            mem_req  = 1'b1;
            mem_addr = desc_addr + ADDR_W'(OFS_ADDR_LO);
         end
         ST_DESC_HI: begin
            mem_req  = 1'b1;
            mem_addr = desc_addr + ADDR_W'(OFS_ADDR_HI);
         end
         ST_WR_DATA: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = data_addr;
            mem_wdata = packed_word;
         end
         ST_WB_LEN: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = desc_addr + ADDR_W'(OFS_LEN);
            mem_wdata = 32'(chunk_cnt_q) + (pkt_end_q ? 32'(FCS_BYTES) : 32'd0);
         end
         ST_WB_STAT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = desc_addr + ADDR_W'(OFS_STATUS);
            mem_wdata = '0;
            mem_wdata[ST_DONE_BIT] = 1'b1;
            mem_wdata[ST_NOCS_BIT] = 1'b1;
            mem_wdata[ST_EOP_BIT]  = pkt_end_q;
         end
         default: ;
      endcase
   end

   // engine sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         buf_addr_q   <= '0;
         chunk_cnt_q  <= '0;
         word_idx_q   <= '0;
         bsize_q      <= '0;
         chunk_end_q  <= 1'b0;
         pkt_end_q    <= 1'b0;
         ev_overrun_q <= 1'b0;
         ev_timer_q   <= 1'b0;
      end else begin
         ev_overrun_q <= 1'b0;
         ev_timer_q   <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (pkt_valid) begin
                  bsize_q <= dec_size;
                  if (!ctrl_q[CTRL_EN_BIT] || !dec_valid) begin
                     state_q <= ST_DRAIN;           // R3, R4
                  end else if (ring_full) begin
                     ev_overrun_q <= 1'b1;          // R10
                     state_q      <= ST_DRAIN;
                  end else begin
                     state_q <= ST_DESC_LO;
                  end
               end
            end
            ST_DESC_LO: begin
               if (mem_ack) begin
                  buf_addr_q[31:0] <= mem_rdata;
                  state_q          <= ST_DESC_HI;
               end
            end
            ST_DESC_HI: begin
               if (mem_ack) begin
                  buf_addr_q[63:32] <= mem_rdata;
                  chunk_cnt_q       <= '0;
                  word_idx_q        <= '0;
                  chunk_end_q       <= 1'b0;
                  pkt_end_q         <= 1'b0;
                  state_q           <= ST_DATA;
               end
            end
            ST_DATA: begin
               if (pkt_valid) begin
                  chunk_cnt_q <= cnt_inc;
                  pkt_end_q   <= pkt_last;
                  chunk_end_q <= chunk_done;
                  if (word_full || chunk_done)
                     state_q <= ST_WR_DATA;
               end
            end
            ST_WR_DATA: begin
               if (mem_ack) begin
                  word_idx_q <= word_idx_q + 1'b1;
                  state_q    <= chunk_end_q ? ST_WB_LEN : ST_DATA;
               end
            end
            ST_WB_LEN: begin
               if (mem_ack)
                  state_q <= ST_WB_STAT;
            end
            ST_WB_STAT: begin
               if (mem_ack) begin
                  if (pkt_end_q) begin
                     ev_timer_q <= 1'b1;            // R11
                     state_q    <= ST_IDLE;
                  end else begin
                     state_q <= ST_NEXT;
                  end
               end
            end
            ST_NEXT: begin
               if (ring_full) begin
                  ev_overrun_q <= 1'b1;             // R10 mid-packet
                  state_q      <= ST_DRAIN;
               end else begin
                  state_q <= ST_DESC_LO;
               end
            end
            ST_DRAIN: begin
               if (pkt_valid && pkt_last)
                  state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rxr_ring_writer_chk.sv
module rxr_ring_writer_chk #(
   parameter int ADDR_W = 64,
   parameter int PTR_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [PTR_W-1:0]  head_q,
   input logic [PTR_W-1:0]  tail_q,
   input logic              pkt_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ack,
   input logic              ev_overrun,
   input logic              ev_rx_timer
);
   assert_ready_excl_mem_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !pkt_ready);

   assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   assert_word_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   assert_timer_after_wb_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rx_timer |-> $past(mem_req && mem_ack && mem_we));

   assert_events_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_overrun && ev_rx_timer));

   assert_overrun_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ev_overrun |-> $past(head_q == tail_q));

   assert_head_moves_on_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((head_q != $past(head_q)) && !$past(reg_we)) |-> $past(mem_ack && mem_we));
endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_we      (reg_we),
   .head_q      (head_q),
   .tail_q      (tail_q),
   .pkt_ready   (pkt_ready),
   .mem_req     (mem_req),
   .mem_we      (mem_we),
   .mem_addr    (mem_addr),
   .mem_ack     (mem_ack),
   .ev_overrun  (ev_overrun),
   .ev_rx_timer (ev_rx_timer)
);

// File: tb/rxr_ring_writer_bench.sv
module rxr_ring_writer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 64;
   localparam int PTR_W  = 16;
   localparam logic [63:0] RING_BASE = 64'h0000_0000_0001_0000;
   localparam logic [31:0] EN = 32'h0000_0002;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_we = 1'b0;
   logic [2:0]        reg_sel = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       ctrl_q;
   logic [ADDR_W-1:0] base_q;
   logic [31:0]       ring_len_q;
   logic [PTR_W-1:0]  head_q;
   logic [PTR_W-1:0]  tail_q;
   logic              pkt_valid = 1'b0;
   logic [7:0]        pkt_data = '0;
   logic              pkt_last = 1'b0;
   logic              pkt_ready;
   logic              mem_req;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [31:0]       mem_wdata;
   logic              mem_ack = 1'b0;
   logic [31:0]       mem_rdata = '0;
   logic              ev_overrun;
   logic              ev_rx_timer;

   int n_chk = 0, n_fail = 0;
   int acc_cnt = 0, ov_cnt = 0, tm_cnt = 0, overlap_cnt = 0, stall_cnt = 0;
   bit [31:0] mem [bit [63:0]];

   always #(CLK_PERIOD/2) clk = ~clk;

   rxr_ring_writer u_rxr_ring_writer (
      .clk, .rst_n, .reg_we, .reg_sel, .reg_wdata, .ctrl_q, .base_q, .ring_len_q,
      .head_q, .tail_q, .pkt_valid, .pkt_data, .pkt_last, .pkt_ready, .mem_req,
      .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata, .ev_overrun, .ev_rx_timer
   );

   function automatic logic [31:0] rd(input logic [63:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   function automatic logic [7:0] exp_byte(input int seed, input int i);
      return 8'(seed + i * 13 + i / 251);
   endfunction

   function automatic logic [63:0] desc_of(input int idx);
      return RING_BASE + 64'(idx * 16);
   endfunction

   function automatic logic [63:0] buf_of(input int idx);
      return {32'h0000_0001, 32'h0020_0000 + 32'(idx) * 32'h0000_8000};
   endfunction

   // memory responder: ack every other cycle
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack = 1'b0;
      end else if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (mem_req) begin
         mem_ack = 1'b1;
         acc_cnt++;
         if (mem_we) mem[mem_addr] = mem_wdata;
         else        mem_rdata = rd(mem_addr);
      end
   end

   // monitors
   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         if (ev_overrun)            ov_cnt++;
         if (ev_rx_timer)           tm_cnt++;
         if (mem_req && pkt_ready)  overlap_cnt++;
         if (pkt_valid && !pkt_ready) stall_cnt++;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic send_pkt(input int len, input int seed);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         pkt_valid = 1'b1;
         pkt_data  = exp_byte(seed, i);
         pkt_last  = (i == len - 1);
         while (!pkt_ready) @(negedge clk);
         @(posedge clk);
      end
      @(negedge clk);
      pkt_valid = 1'b0;
      pkt_last  = 1'b0;
      repeat (20) @(negedge clk);
   endtask

   task automatic prep(input logic [31:0] ctrl, input int head, input int tail);
      mem.delete();
      for (int i = 0; i < 8; i++) begin
         mem[desc_of(i)]     = buf_of(i)[31:0];
         mem[desc_of(i) + 4] = buf_of(i)[63:32];
      end
      reg_wr(3'd0, ctrl);
      reg_wr(3'd4, 32'(head));
      reg_wr(3'd5, 32'(tail));
   endtask

   task automatic chk_chunk(input string req, input int didx, input int start,
                            input int clen, input bit last, input int seed);
      logic [63:0] b;
      logic [31:0] w;
      int bad;
      b = buf_of(didx);
      bad = 0;
      for (int j = 0; j < ((clen + 3) / 4) * 4; j++) begin
         w = rd(b + 64'(4 * (j / 4)));
         if (j < clen) begin
            if (w[8*(j%4) +: 8] !== exp_byte(seed, start + j)) bad++;
         end else if (w[8*(j%4) +: 8] !== 8'h00) begin
            bad++;
         end
      end
      chk(req, "payload bytes in error", 64'(bad), 64'd0);
      chk("R8", "length word", 64'(rd(desc_of(didx) + 8)), 64'(clen + (last ? 4 : 0)));
      chk("R8", "status word", 64'(rd(desc_of(didx) + 12)), last ? 64'h7 : 64'h5);
   endtask

   task automatic t_reset;
      chk("R1", "ctrl after reset", 64'(ctrl_q), 64'h0);
      chk("R1", "ring length after reset", 64'(ring_len_q), 64'h0);
      chk("R1", "head after reset", 64'(head_q), 64'h0);
      chk("R1", "tail after reset", 64'(tail_q), 64'h0);
      chk("R1", "ready/req/events after reset",
          {60'h0, pkt_ready, mem_req, ev_overrun, ev_rx_timer}, 64'h0);
   endtask

   task automatic t_regs;
      reg_wr(3'd3, 32'hFFFF_FFFF);
      chk("R2", "ring length mask", 64'(ring_len_q), 64'h000F_FF80);
      reg_wr(3'd4, 32'h0001_2345);
      chk("R2", "head keeps 16 bits", 64'(head_q), 64'h2345);
      reg_wr(3'd5, 32'hABCD_0006);
      chk("R2", "tail keeps 16 bits", 64'(tail_q), 64'h0006);
      reg_wr(3'd3, 32'd128);
      reg_wr(3'd1, RING_BASE[31:0]);
      reg_wr(3'd2, RING_BASE[63:32]);
      chk("R2", "base readback", 64'(base_q), RING_BASE);
   endtask

   task automatic t_disabled;
      int a0, t0;
      prep(32'h0003_0000, 2, 6);
      a0 = acc_cnt; t0 = tm_cnt + ov_cnt;
      send_pkt(10, 3);
      chk("R3", "memory accesses while disabled", 64'(acc_cnt - a0), 64'd0);
      chk("R3", "events while disabled", 64'(tm_cnt + ov_cnt - t0), 64'd0);
      chk("R3", "head while disabled", 64'(head_q), 64'd2);
   endtask

   task automatic t_single;
      int a0, t0;
      prep(EN, 0, 4);
      a0 = acc_cnt; t0 = tm_cnt;
      send_pkt(7, 8'h11);
      chk("R5", "access count for 7-byte packet", 64'(acc_cnt - a0), 64'd6);
      chk_chunk("R6", 0, 0, 7, 1'b1, 8'h11);
      chk("R6", "padded last word",
          64'(rd(buf_of(0) + 4)), 64'({8'h00, exp_byte(8'h11, 6), exp_byte(8'h11, 5), exp_byte(8'h11, 4)}));
      chk("R9", "head after one descriptor", 64'(head_q), 64'd1);
      chk("R11", "one timer pulse", 64'(tm_cnt - t0), 64'd1);
   endtask

   task automatic t_split;
      int t0;
      prep(EN | 32'h0003_0000, 0, 4);
      t0 = tm_cnt;
      send_pkt(600, 8'h40);
      chk_chunk("R7", 0, 0,   256, 1'b0, 8'h40);
      chk_chunk("R7", 1, 256, 256, 1'b0, 8'h40);
      chk_chunk("R7", 2, 512, 88,  1'b1, 8'h40);
      chk("R9", "head after three chunks", 64'(head_q), 64'd3);
      chk("R11", "one timer pulse per split packet", 64'(tm_cnt - t0), 64'd1);
      chk("R12", "packet stalled during memory traffic", 64'(stall_cnt > 0), 64'd1);
   endtask

   task automatic t_sizes;
      prep(EN | 32'h0001_0000, 0, 4);
      send_pkt(1024, 8'h5A);
      chk_chunk("R4", 0, 0, 1024, 1'b1, 8'h5A);
      chk("R4", "next descriptor untouched at exact fit", 64'(rd(desc_of(1) + 8)), 64'd0);
      prep(EN | 32'h0002_0000, 0, 4);
      send_pkt(513, 8'h21);
      chk_chunk("R4", 0, 0, 512, 1'b0, 8'h21);
      chk_chunk("R4", 1, 512, 1, 1'b1, 8'h21);
      prep(EN | 32'h0203_0000, 0, 4);
      send_pkt(4100, 8'h77);
      chk_chunk("R4", 0, 0, 4096, 1'b0, 8'h77);
      chk_chunk("R4", 1, 4096, 4, 1'b1, 8'h77);
      chk("R9", "head after extended-size packet", 64'(head_q), 64'd2);
   endtask

   task automatic t_invalid;
      int a0, t0;
      prep(EN | 32'h0200_0000, 1, 5);
      a0 = acc_cnt; t0 = tm_cnt + ov_cnt;
      send_pkt(20, 9);
      chk("R4", "no access with invalid size", 64'(acc_cnt - a0), 64'd0);
      chk("R4", "no event with invalid size", 64'(tm_cnt + ov_cnt - t0), 64'd0);
      chk("R4", "head with invalid size", 64'(head_q), 64'd1);
   endtask

   task automatic t_wrap;
      prep(EN | 32'h0003_0000, 7, 2);
      send_pkt(300, 8'h90);
      chk_chunk("R9", 7, 0, 256, 1'b0, 8'h90);
      chk_chunk("R9", 0, 256, 44, 1'b1, 8'h90);
      chk("R9", "head wraps past last entry", 64'(head_q), 64'd1);
   endtask

   task automatic t_overrun;
      int a0, o0, t0;
      prep(EN, 4, 4);
      a0 = acc_cnt; o0 = ov_cnt; t0 = tm_cnt;
      send_pkt(10, 1);
      chk("R10", "overrun pulse on full ring", 64'(ov_cnt - o0), 64'd1);
      chk("R10", "no access on full ring", 64'(acc_cnt - a0), 64'd0);
      chk("R10", "head held on full ring", 64'(head_q), 64'd4);
      chk("R11", "no timer on dropped packet", 64'(tm_cnt - t0), 64'd0);
      prep(EN | 32'h0003_0000, 0, 1);
      o0 = ov_cnt; t0 = tm_cnt;
      send_pkt(300, 8'h33);
      chk_chunk("R10", 0, 0, 256, 1'b0, 8'h33);
      chk("R10", "overrun pulse mid-packet", 64'(ov_cnt - o0), 64'd1);
      chk("R10", "second descriptor untouched", 64'(rd(desc_of(1) + 12)), 64'd0);
      chk("R10", "head after mid-packet overrun", 64'(head_q), 64'd1);
      chk("R11", "no timer after mid-packet overrun", 64'(tm_cnt - t0), 64'd0);
   endtask

   task automatic t_collide;
      bit hit;
      prep(EN, 0, 5);
      hit = 1'b0;
      fork
         send_pkt(4, 8'h6C);
         begin
            for (int k = 0; k < 200 && !hit; k++) begin
               @(negedge clk);
               #1;
               if (mem_ack && mem_we && mem_addr == desc_of(0) + 12) begin
                  reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = 32'd3;
                  hit = 1'b1;
                  @(negedge clk);
                  reg_we = 1'b0;
               end
            end
         end
      join
      chk("R13", "collision provoked", 64'(hit), 64'd1);
      chk("R13", "advance wins over head write", 64'(head_q), 64'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_regs();
      t_disabled();
      t_single();
      t_split();
      t_sizes();
      t_invalid();
      t_wrap();
      t_overrun();
      t_collide();
      chk("R12", "ready never high during a request", 64'(overlap_cnt), 64'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule